// File: doc/BRIEF.md
# Fast Page Mode DRAM Control and Output Logic

This block models the control side of an asynchronous fast page mode dynamic RAM. It runs from a fast system clock. The active-low row strobe, column strobe, write enable and output enable pins, the multiplexed address and the write data all pass through a two-flop synchronizer. The block then decodes edges of the synchronized strobes to tell the cycle types apart: read, early write, late write, read-modify-write, page-mode column cycles, row-only refresh and column-before-row refresh.

The block holds a row latch and a column latch. The column latch is flow-through: it follows the address pins while the column strobe is high. The block also holds the internal refresh row counter, a small single-port storage array and the output data latch with its driver enable. The data bus is split into `dq_in`, `dq_out` and a driver enable `dq_oe`, so a pad ring can build the bidirectional pins. Each row activation is reported on `rfsh_row`/`rfsh_go`, so the row being refreshed can be seen at the ports.

The array uses the low `ROW_BITS` bits of the row address and the low `COL_BITS` bits of the column address. The word index is {row bits, column bits}. The full `ADDR_W`-bit row value is still reported on `rfsh_row`.

Top module: `pgdram_core`

## Requirements
- R1: While `rst` is high and after it falls, `dq_oe` is 0, `rfsh_go` is 0, `rfsh_row` is 0 and the internal refresh counter is 0.
- R2: A row strobe fall with the column strobe high latches the row. A later column strobe fall with `we_n` high reads the word at {row, column}. That word appears on `dq_out` with `dq_oe` at 1 while `oe_n` is low, no more than six clock cycles after the strobe change.
- R3: While the column strobe is high, the column latch follows `addr`. The column used is the address present at the column strobe fall. Address changes made after the fall do not alter the selected column, including for a write made later in the same column cycle.
- R4: If `we_n` is already low when the column strobe falls (early write), `dq_in` is written to the addressed word and `dq_oe` stays 0 for the whole column cycle.
- R5: If `we_n` falls while the column strobe is low in a read access (late write), `dq_in` at the `we_n` fall is written to the latched column. `dq_oe` is 0 while `we_n` is low, and stays 0 throughout when `oe_n` is high.
- R6: In a read-modify-write, the old word is driven before `we_n` falls. The new word is stored. After `we_n` rises again with the column strobe still low, the old word is driven again.
- R7: `oe_n` high forces `dq_oe` to 0 without changing `dq_out`. `dq_out` changes only when a new read completes.
- R8: A column strobe rise sets `dq_oe` to 0. A row strobe rise while the column strobe stays low keeps driving the same data.
- R9: Several column cycles under one row strobe low period reuse the latched row, in any mix of reads and writes.
- R10: A column strobe pulse while the row strobe is high changes no stored word, leaves `dq_oe` at 0 and produces no `rfsh_go`.
- R11: Every row strobe fall gives a one-cycle `rfsh_go` pulse. A normal activation reports the full row address on `rfsh_row`. A row-only cycle with no column strobe leaves `dq_oe` at 0.
- R12: If the column strobe fell while the row strobe was high, and has not risen since, the next row strobe fall is a column-before-row refresh. `rfsh_row` takes the internal counter value and `addr` is ignored. The counter then increments, wrapping from 511 to 0. No data is accessed, and `dq_oe` and `dq_out` keep their prior values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data from the pads |
| dq_out | output | DATA_W | Output data latch |
| dq_oe | output | 1 | Output driver enable for the pads |
| rfsh_row | output | ADDR_W | Row activated by the last row strobe fall |
| rfsh_go | output | 1 | One-cycle pulse on each row activation |

## Verification
The bench builds the block with `ROW_BITS=3` and `COL_BITS=3`, a 64-word array. With that size, random rows and columns collide often. Writes of every kind are therefore read back many times through reads, page cycles and read-modify-writes. `ADDR_W` stays at 9, so more than 512 column-before-row cycles carry the refresh counter through its wrap from 511 to 0 within the run. It also lets row values above the array range show up unchanged on `rfsh_row`.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  // Synchronized strobe levels, all active low as at the pins.
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } strobes_t;

  typedef enum logic [1:0] {
    ROW_IDLE   = 2'd0,
    ROW_ACTIVE = 2'd1,
    ROW_RFSH   = 2'd2
  } row_st_t;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;

endpackage

// File: rtl/pgdram_sync.sv
module pgdram_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/pgdram_array.sv
module pgdram_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= d;
      else    q         <= mem[addr];
    end
  end

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int MEM_AW  = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  input  logic [DATA_W-1:0] mem_q,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_d,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              rfsh_go,
  output logic [ADDR_W-1:0] rfsh_cnt,
  output logic              cbr_start,
  output logic              row_open
);

  strobes_t              strb_q;
  row_st_t               row_st;
  acc_t                  acc;
  logic                  cbr_arm;
  logic [ROW_BITS-1:0]   row_lat;
  logic [COL_BITS-1:0]   col_lat;
  logic [COL_BITS-1:0]   col_sel;
  logic                  rd_pend;
  logic                  io_en;
  logic                  ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic                  start_acc, late_wr;

  // Edges of the synchronized strobes.
  assign ras_fall = strb_q.ras & ~strb.ras;
  assign ras_rise = ~strb_q.ras & strb.ras;
  assign cas_fall = strb_q.cas & ~strb.cas;
  assign cas_rise = ~strb_q.cas & strb.cas;
  assign we_fall  = strb_q.we & ~strb.we;

  // Flow-through column latch: open while the previous CAS sample was high.
  assign col_sel = strb_q.cas ? addr_s[COL_BITS-1:0] : col_lat;

  assign row_open  = (row_st == ROW_ACTIVE);
  assign cbr_start = ras_fall & cbr_arm;
  assign start_acc = cas_fall & ~strb.ras & row_open;
  assign late_wr   = we_fall & ~strb.cas & ~strb.ras & row_open & (acc != ACC_NONE);

  assign mem_en   = start_acc | late_wr;
  assign mem_we   = (start_acc & ~strb.we) | late_wr;
  assign mem_addr = {row_lat, col_sel};
  assign mem_d    = din_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q   <= '1;
      row_st   <= ROW_IDLE;
      acc      <= ACC_NONE;
      cbr_arm  <= 1'b0;
      row_lat  <= '0;
      col_lat  <= '0;
      rfsh_cnt <= '0;
      rfsh_row <= '0;
      rfsh_go  <= 1'b0;
      rd_pend  <= 1'b0;
      io_en    <= 1'b0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else begin
      strb_q  <= strb;
      col_lat <= col_sel;
      rfsh_go <= ras_fall;

      // Row activation: external row or internal refresh counter.
      if (ras_fall) begin
        if (cbr_arm) begin
          row_st   <= ROW_RFSH;
          rfsh_row <= rfsh_cnt;
          rfsh_cnt <= rfsh_cnt + 1'b1;
        end else begin
          row_st   <= ROW_ACTIVE;
          row_lat  <= addr_s[ROW_BITS-1:0];
          rfsh_row <= addr_s;
        end
      end else if (ras_rise) begin
        row_st <= ROW_IDLE;
      end

      // CAS fall while RAS is high arms a refresh-only cycle.
      if (ras_fall || cas_rise)       cbr_arm <= 1'b0;
      else if (cas_fall && strb.ras)  cbr_arm <= 1'b1;

      if (start_acc)     acc <= strb.we ? ACC_READ : ACC_WRITE;
      else if (cas_rise) acc <= ACC_NONE;

      rd_pend <= start_acc & strb.we;

      if (rd_pend) dq_out <= mem_q;

      if (cas_rise)     io_en <= 1'b0;
      else if (rd_pend) io_en <= 1'b1;

      dq_oe <= io_en & ~strb.cas & ~strb.oe & strb.we;
    end
  end

endmodule

// File: rtl/pgdram_core.sv
module pgdram_core
  import pgdram_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int ROW_BITS    = 4,
  parameter int COL_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              rfsh_go
);

  localparam int MEM_AW = ROW_BITS + COL_BITS;
  localparam int BUS_W  = ADDR_W + DATA_W;

  logic [3:0]        strb_raw;
  strobes_t          strb;
  logic [BUS_W-1:0]  bus_s;
  logic              arr_en, arr_we;
  logic [MEM_AW-1:0] arr_addr;
  logic [DATA_W-1:0] arr_d, arr_q;
  logic [ADDR_W-1:0] rfsh_cnt;
  logic              cbr_start, row_open;

  pgdram_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_strb_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ras_n, cas_n, we_n, oe_n}),
    .q   (strb_raw)
  );

  assign strb = strobes_t'(strb_raw);

  // Address and data ride the same pipeline so they stay aligned to the strobes.
  pgdram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({addr, dq_in}),
    .q   (bus_s)
  );

  pgdram_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .addr_s    (bus_s[BUS_W-1:DATA_W]),
    .din_s     (bus_s[DATA_W-1:0]),
    .mem_q     (arr_q),
    .mem_en    (arr_en),
    .mem_we    (arr_we),
    .mem_addr  (arr_addr),
    .mem_d     (arr_d),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .rfsh_row  (rfsh_row),
    .rfsh_go   (rfsh_go),
    .rfsh_cnt  (rfsh_cnt),
    .cbr_start (cbr_start),
    .row_open  (row_open)
  );

  pgdram_array #(.AW(MEM_AW), .DW(DATA_W)) u_array (
    .clk  (clk),
    .en   (arr_en),
    .we   (arr_we),
    .addr (arr_addr),
    .d    (arr_d),
    .q    (arr_q)
  );

endmodule

// File: rtl/pgdram_core_chk.sv
module pgdram_core_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic              rfsh_go,
  input logic [ADDR_W-1:0] rfsh_cnt,
  input logic              cbr_start,
  input logic              arr_we,
  input logic              row_open
);

  AST_CNT_MOVES_ON_CBR: assert property (@(posedge clk) disable iff (rst)
    !$stable(rfsh_cnt) |-> $past(cbr_start)); // R12

  AST_WRITE_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> row_open); // R10

  AST_DATA_HELD_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R7

  AST_RFSH_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rfsh_go |=> !rfsh_go); // R11

  AST_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> !dq_oe); // R5

endmodule

bind pgdram_core pgdram_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .rfsh_go   (rfsh_go),
  .rfsh_cnt  (rfsh_cnt),
  .cbr_start (cbr_start),
  .arr_we    (arr_we),
  .row_open  (row_open)
);

// File: tb/pgdram_core_tb.sv
`timescale 1ns/1ps
module pgdram_core_tb;

  localparam int AW = 9;
  localparam int DW = 8;
  localparam int RB = 3;
  localparam int CB = 3;
  localparam int WORDS = 1 << (RB + CB);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [AW-1:0] rfsh_row;
  logic          rfsh_go;

  int checks = 0;
  int fails = 0;
  int go_cnt = 0;
  int go_exp = 0;
  int cbr_ref = 0;
  bit finished = 0;
  logic [DW-1:0] ref_mem [WORDS];

  always #2.5 clk = ~clk;

  pgdram_core #(.ADDR_W(AW), .DATA_W(DW), .ROW_BITS(RB), .COL_BITS(CB)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .rfsh_row(rfsh_row), .rfsh_go(rfsh_go)
  );

  always @(posedge clk) if (!rst && rfsh_go) go_cnt <= go_cnt + 1;

  function automatic int ix(logic [AW-1:0] r, logic [AW-1:0] c);
    return int'({r[RB-1:0], c[CB-1:0]});
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic open_row(logic [AW-1:0] r);
    addr = r; ras_n = 1'b0; settle();
    go_exp++;
    chk("R11 rfsh_row on activation", 32'(rfsh_row), 32'(r));
    chk("R11 one pulse per activation", go_cnt, go_exp);
  endtask

  task automatic close_row();
    ras_n = 1'b1; settle();
  endtask

  task automatic col_read(logic [AW-1:0] r, logic [AW-1:0] c);
    addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; settle();
    chk("R2 read drive", 32'(dq_oe), 1);
    chk("R2 R9 read data", 32'(dq_out), 32'(ref_mem[ix(r, c)]));
    cas_n = 1'b1; settle();
    chk("R8 cas rise ends drive", 32'(dq_oe), 0);
  endtask

  task automatic col_ewrite(logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d);
    addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; settle();
    chk("R4 early write no drive", 32'(dq_oe), 0);
    cas_n = 1'b1; settle();
    chk("R4 early write no drive after", 32'(dq_oe), 0);
    we_n = 1'b1;
    ref_mem[ix(r, c)] = d;
  endtask

  task automatic col_lwrite(logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d);
    addr = c; we_n = 1'b1; oe_n = 1'b1; cas_n = 1'b0; settle();
    chk("R5 late write oe high no drive", 32'(dq_oe), 0);
    din = d; we_n = 1'b0; settle();
    chk("R5 late write we low no drive", 32'(dq_oe), 0);
    cas_n = 1'b1; settle();
    we_n = 1'b1; oe_n = 1'b0;
    ref_mem[ix(r, c)] = d;
  endtask

  task automatic col_rmw(logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d);
    logic [DW-1:0] old;
    old = ref_mem[ix(r, c)];
    addr = c; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; settle();
    chk("R6 rmw read drive", 32'(dq_oe), 1);
    chk("R6 rmw read data", 32'(dq_out), 32'(old));
    din = d; we_n = 1'b0; settle();
    chk("R6 rmw we low no drive", 32'(dq_oe), 0);
    we_n = 1'b1; settle();
    chk("R6 rmw drive again", 32'(dq_oe), 1);
    chk("R6 rmw old word kept", 32'(dq_out), 32'(old));
    cas_n = 1'b1; settle();
    ref_mem[ix(r, c)] = d;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] r, c, ca, cb;
    logic [DW-1:0] d, held;
    void'($urandom(32'h5A17C3E1));
    repeat (4) @(negedge clk);
    chk("R1 dq_oe in reset", 32'(dq_oe), 0);
    chk("R1 rfsh_go in reset", 32'(rfsh_go), 0);
    rst = 1'b0;
    settle();
    chk("R1 dq_oe after reset", 32'(dq_oe), 0);
    chk("R1 rfsh_row after reset", 32'(rfsh_row), 0);
    chk("R1 no pulses", go_cnt, 0);

    // Fill every word with page-mode early writes (R4, R9).
    for (int rr = 0; rr < (1 << RB); rr++) begin
      open_row(AW'(rr + 8 * ($urandom % 64)));
      for (int cc = 0; cc < (1 << CB); cc++)
        col_ewrite(AW'(rr), AW'(cc + 8 * ($urandom % 64)), DW'($urandom));
      close_row();
    end

    // R2 plain reads, high row bits beyond the array range.
    open_row(9'h1F3); col_read(9'h1F3, 9'h0A5); close_row();
    open_row(9'h004); col_read(9'h004, 9'h007); close_row();

    // R3 flow-through column latch.
    r = 9'h002; ca = 9'h001; cb = 9'h006;
    open_row(r);
    addr = ca; settle();
    addr = cb; settle();
    cas_n = 1'b0; settle();
    chk("R3 column taken at cas fall", 32'(dq_out), 32'(ref_mem[ix(r, cb)]));
    addr = ca; oe_n = 1'b1; din = 8'h3C; we_n = 1'b0; settle();
    chk("R5 late write no drive", 32'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; settle();
    ref_mem[ix(r, cb)] = 8'h3C;
    col_read(r, cb);
    col_read(r, ca);
    chk("R3 write went to latched column", 32'(ref_mem[ix(r, cb)]), 32'h3C);
    close_row();

    // R5 and R6 directed.
    open_row(9'h005); col_lwrite(9'h005, 9'h003, 8'hA5); col_read(9'h005, 9'h003); close_row();
    open_row(9'h006); col_rmw(9'h006, 9'h002, 8'h5A); col_read(9'h006, 9'h002); close_row();

    // R7 OE gating.
    open_row(9'h001);
    addr = 9'h004; cas_n = 1'b0; settle();
    held = dq_out;
    oe_n = 1'b1; settle();
    chk("R7 oe high no drive", 32'(dq_oe), 0);
    chk("R7 oe keeps data", 32'(dq_out), 32'(held));
    oe_n = 1'b0; settle();
    chk("R7 oe low drives again", 32'(dq_oe), 1);
    cas_n = 1'b1; settle();
    close_row();

    // R8 RAS rise while CAS low keeps drive.
    open_row(9'h003);
    addr = 9'h005; cas_n = 1'b0; settle();
    ras_n = 1'b1; settle();
    chk("R8 drive kept after ras rise", 32'(dq_oe), 1);
    chk("R8 data kept after ras rise", 32'(dq_out), 32'(ref_mem[ix(9'h003, 9'h005)]));
    cas_n = 1'b1; settle();
    chk("R8 cas rise ends drive", 32'(dq_oe), 0);

    // R10 CAS-only cycle with a write attempt.
    addr = 9'h00D; din = ~ref_mem[ix(9'h000, 9'h00D)]; we_n = 1'b0; cas_n = 1'b0; settle();
    chk("R10 cas-only no drive", 32'(dq_oe), 0);
    cas_n = 1'b1; settle(); we_n = 1'b1;
    chk("R10 cas-only no pulse", go_cnt, go_exp);
    open_row(9'h000); col_read(9'h000, 9'h00D); close_row();

    // R11 RAS-only refresh.
    open_row(9'h1AB);
    chk("R11 ras-only no drive", 32'(dq_oe), 0);
    close_row();

    // R12 CAS-before-RAS refresh through the counter wrap.
    held = dq_out;
    for (int k = 0; k < 515; k++) begin
      cas_n = 1'b0; settle();
      addr = AW'($urandom); ras_n = 1'b0; settle();
      go_exp++;
      chk("R12 counter row", 32'(rfsh_row), 32'(cbr_ref));
      chk("R12 no drive", 32'(dq_oe), 0);
      chk("R12 data kept", 32'(dq_out), 32'(held));
      ras_n = 1'b1; settle();
      cas_n = 1'b1; settle();
      cbr_ref = (cbr_ref + 1) % 512;
    end
    chk("R12 pulses counted", go_cnt, go_exp);

    // Random mix of page-mode cycles.
    for (int n = 0; n < 250; n++) begin
      r = AW'($urandom);
      open_row(r);
      for (int p = 0; p <= int'($urandom % 3); p++) begin
        c = AW'($urandom); d = DW'($urandom);
        case ($urandom % 4)
          0: col_read(r, c);
          1: col_ewrite(r, c, d);
          2: col_lwrite(r, c, d);
          default: col_rmw(r, c, d);
        endcase
      end
      close_row();
    end

    finished = 1;
    finish_run();
  end

endmodule